// File: doc/BRIEF.md
# Emulated Parity Error Injector

This block sits next to a memory that keeps no parity bits. It lets a processor self-test that deliberately writes data with bad parity still receive the error it expects. The block watches the memory bus: an address, a read strobe, a write strobe and a control bit that asks for wrong parity on writes. It stores no parity at all. It remembers the address of the most recent write made with wrong parity forced. When that address is read back, it raises a parity error flag.

The block tracks one address at a time. A write with forced bad parity always takes over the tracked slot. A plain write to the tracked address releases it. Every strobe is sampled on the rising edge of the single system clock. The error flag is registered, so it follows the read that caused it by one cycle. There is no data stream, so every pin is a plain level signal sampled each clock. There is no valid/ready handshake and no back-pressure.

Top module: `perr_injector`

## Requirements
- R1: A cycle with `bus_wr`=1 and `bus_force_bad`=1 stores `bus_addr` as the tracked address and arms the tracker. That write by itself does not raise `parity_err`.
- R2: A cycle with `bus_rd`=1 and `bus_addr` equal to the armed tracked address makes `parity_err` read 1 during the next clock cycle.
- R3: A cycle with `bus_wr`=1, `bus_force_bad`=0 and `bus_addr` equal to the tracked address disarms the tracker. Later reads of that address leave `parity_err` at 0.
- R4: A forced-bad-parity write to a new address replaces the tracked address. Reads of the old address then leave `parity_err` at 0.
- R5: A read of any address other than the tracked one leaves `parity_err` at 0 in the next cycle. So does any read while the tracker is disarmed. This holds even when the two addresses differ only in their top bit.
- R6: A write with `bus_force_bad`=0 to an address other than the tracked one leaves the tracker unchanged.
- R7: `rst`=1 at a clock edge disarms the tracker and drives `parity_err` to 0 from that edge.
- R8: `parity_err` stays 1 as long as a matching read continues. It returns to 0 in the cycle after the first edge at which `bus_rd` is sampled 0.
- R9: When a read and a write fall in the same cycle, the read is compared against the tracker state from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | AW (24) | Bus address of the current cycle |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_force_bad | input | 1 | Requests wrong parity on this write |
| parity_err | output | 1 | Emulated parity error, registered |

## Verification
Each result appears exactly one clock after the edge that samples its stimulus. A read that hits shows `parity_err` high in the following cycle. A tracker update made by a write first affects reads sampled at the next edge. The flag drops one cycle after the read strobe is sampled low. The bench drives each stimulus after a falling edge and lets one rising edge pass. It then compares the output at the next falling edge against a behavioural model that has advanced by that same one edge. This keeps every comparison in the cycle in which the result is due.

// File: rtl/perr_pkg.sv
package perr_pkg;
  localparam int unsigned DEF_AW      = 24;
  localparam int unsigned DEF_SLICE_W = 8;

  // Classified bus activity for one clock cycle.
  typedef struct packed {
    logic rd;
    logic wr_clean;
    logic wr_bad;
  } bus_op_t;
endpackage

// File: rtl/perr_bus_decode.sv
module perr_bus_decode
  import perr_pkg::*;
(
  input  logic    bus_rd,
  input  logic    bus_wr,
  input  logic    bus_force_bad,
  output bus_op_t op
);
  always_comb begin
    op.rd       = bus_rd;
    op.wr_bad   = bus_wr & bus_force_bad;
    op.wr_clean = bus_wr & ~bus_force_bad;
  end
endmodule

// File: rtl/perr_addr_track.sv
module perr_addr_track #(
  parameter int unsigned AW      = perr_pkg::DEF_AW,
  parameter int unsigned SLICE_W = perr_pkg::DEF_SLICE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_bad,
  input  logic          wr_clean,
  input  logic [AW-1:0] addr,
  output logic          hit
);
  localparam int unsigned NSLICE = (AW + SLICE_W - 1) / SLICE_W;
  localparam int unsigned PADW   = NSLICE * SLICE_W;

  logic [AW-1:0]     lat_addr;
  logic              lat_valid;
  logic [PADW-1:0]   a_pad;
  logic [PADW-1:0]   l_pad;
  logic [NSLICE-1:0] slice_eq;
  logic              addr_eq;

  assign a_pad = PADW'(addr);
  assign l_pad = PADW'(lat_addr);

  // Address compare split into equal slices, then reduced.
  for (genvar i = 0; i < NSLICE; i++) begin : g_slice
    assign slice_eq[i] = (a_pad[i*SLICE_W +: SLICE_W] == l_pad[i*SLICE_W +: SLICE_W]);
  end

  assign addr_eq = &slice_eq;
  assign hit     = lat_valid & addr_eq;

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_valid <= 1'b0;
      lat_addr  <= '0;
    end else if (wr_bad) begin
      lat_valid <= 1'b1;
      lat_addr  <= addr;
    end else if (wr_clean && addr_eq) begin
      lat_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/perr_err_flag.sv
module perr_err_flag (
  input  logic clk,
  input  logic rst,
  input  logic rd,
  input  logic hit,
  output logic err
);
  always_ff @(posedge clk) begin
    if (rst) err <= 1'b0;
    else     err <= rd & hit;
  end
endmodule

// File: rtl/perr_injector.sv
module perr_injector
  import perr_pkg::*;
#(
  parameter int unsigned AW      = DEF_AW,
  parameter int unsigned SLICE_W = DEF_SLICE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic          bus_force_bad,
  output logic          parity_err
);
  bus_op_t op;
  logic    hit;

  perr_bus_decode u_dec (
    .bus_rd        (bus_rd),
    .bus_wr        (bus_wr),
    .bus_force_bad (bus_force_bad),
    .op            (op)
  );

  perr_addr_track #(.AW(AW), .SLICE_W(SLICE_W)) u_track (
    .clk      (clk),
    .rst      (rst),
    .wr_bad   (op.wr_bad),
    .wr_clean (op.wr_clean),
    .addr     (bus_addr),
    .hit      (hit)
  );

  perr_err_flag u_flag (
    .clk (clk),
    .rst (rst),
    .rd  (op.rd),
    .hit (hit),
    .err (parity_err)
  );
endmodule

// File: rtl/perr_injector_chk.sv
module perr_injector_chk #(
  parameter int unsigned AW = perr_pkg::DEF_AW
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] bus_addr,
  input logic          bus_rd,
  input logic          bus_wr,
  input logic          bus_force_bad,
  input logic          parity_err
);
  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> !parity_err); // R7

  AST_NO_READ_NO_ERR: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> !parity_err); // R8

  AST_FORCED_THEN_HIT: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_force_bad) ##1 (bus_rd && !bus_wr && !rst && bus_addr == $past(bus_addr))
    |=> parity_err); // R2

  AST_CLEAN_THEN_QUIET: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !bus_force_bad) ##1 (bus_rd && !bus_wr && bus_addr == $past(bus_addr))
    |=> !parity_err); // R3

  AST_BAD_WRITE_NO_ERR: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_force_bad && !bus_rd) |=> !parity_err); // R1
endmodule

bind perr_injector perr_injector_chk #(.AW(AW)) chk_i (
  .clk           (clk),
  .rst           (rst),
  .bus_addr      (bus_addr),
  .bus_rd        (bus_rd),
  .bus_wr        (bus_wr),
  .bus_force_bad (bus_force_bad),
  .parity_err    (parity_err)
);

// File: tb/perr_injector_tb_top.sv
module perr_injector_tb_top;
  localparam int unsigned AW       = 24;
  localparam time         CLK_HALF = 5ns;
  localparam int          WD_LIMIT = 5000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_rd = 1'b0;
  logic          bus_wr = 1'b0;
  logic          bus_force_bad = 1'b0;
  logic          parity_err;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit done     = 0;

  // Behavioural reference state
  bit ref_armed = 0;
  int ref_addr  = 0;
  bit ref_err   = 0;

  always #(CLK_HALF) clk = ~clk;

  perr_injector #(.AW(AW)) dut_i (
    .clk           (clk),
    .rst           (rst),
    .bus_addr      (bus_addr),
    .bus_rd        (bus_rd),
    .bus_wr        (bus_wr),
    .bus_force_bad (bus_force_bad),
    .parity_err    (parity_err)
  );

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WD_LIMIT && !done) begin
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual=hung expected=finished");
        finish_run();
      end
    end
  end

  // One bus cycle: drive, let one rising edge pass, compare at the falling edge.
  task automatic step(input bit r, input bit w, input bit f, input int a,
                      input bit rs, input string req);
    bus_rd = r; bus_wr = w; bus_force_bad = f; bus_addr = AW'(a); rst = rs;
    @(posedge clk);
    if (rs) begin
      ref_err   = 0;
      ref_armed = 0;
    end else begin
      ref_err = r && ref_armed && (a == ref_addr);
      if (w && f) begin
        ref_armed = 1;
        ref_addr  = a;
      end else if (w && !f && a == ref_addr) begin
        ref_armed = 0;
      end
    end
    @(negedge clk);
    n_checks++;
    if (parity_err !== ref_err) begin
      n_fail++;
      $display("FAIL %s: parity_err actual=%0b expected=%0b", req, parity_err, ref_err);
    end
  endtask

  initial begin
    @(negedge clk);
    step(0, 0, 0, 0, 1, "R7");
    step(0, 0, 0, 0, 1, "R7");
    // R5: read while disarmed
    step(1, 0, 0, 'h100, 0, "R5");
    step(1, 0, 0, 0, 0, "R5");
    // R1: forced write alone raises nothing
    step(0, 1, 1, 'h123456, 0, "R1");
    step(0, 0, 0, 0, 0, "R1");
    // R2 / R8: held read then release
    step(1, 0, 0, 'h123456, 0, "R2");
    step(1, 0, 0, 'h123456, 0, "R8");
    step(1, 0, 0, 'h123456, 0, "R8");
    step(0, 0, 0, 'h123456, 0, "R8");
    step(0, 0, 0, 0, 0, "R8");
    // R5: neighbouring and top-bit-only different addresses
    step(1, 0, 0, 'h123457, 0, "R5");
    step(1, 0, 0, 'h923456, 0, "R5");
    // R6: clean write elsewhere keeps tracker
    step(0, 1, 0, 'h000010, 0, "R6");
    step(1, 0, 0, 'h123456, 0, "R6");
    step(0, 0, 0, 0, 0, "R6");
    // R4: replacement
    step(0, 1, 1, 'h0ABCDE, 0, "R4");
    step(1, 0, 0, 'h123456, 0, "R4");
    step(1, 0, 0, 'h0ABCDE, 0, "R4");
    step(0, 0, 0, 0, 0, "R4");
    // R9: read with clean write in same cycle sees old state
    step(1, 1, 0, 'h0ABCDE, 0, "R9");
    // R3: then disarmed
    step(1, 0, 0, 'h0ABCDE, 0, "R3");
    step(0, 0, 0, 0, 0, "R3");
    // R9: read with forced write to a new address in same cycle
    step(1, 1, 1, 'h000000, 0, "R9");
    step(1, 0, 0, 'h000000, 0, "R9");
    step(1, 0, 0, 'h800000, 0, "R5");
    // R7: reset while armed and reading
    step(1, 0, 0, 'h000000, 1, "R7");
    step(1, 0, 0, 'h000000, 0, "R7");
    step(0, 0, 0, 0, 0, "R7");
    // Re-arm after reset, then clean write clears
    step(0, 1, 1, 'hFFFFFF, 0, "R1");
    step(1, 0, 0, 'hFFFFFF, 0, "R2");
    step(0, 1, 0, 'hFFFFFF, 0, "R3");
    step(1, 0, 0, 'hFFFFFF, 0, "R3");
    step(0, 0, 0, 0, 0, "R3");
    done = 1;
    finish_run();
  end
endmodule